// File: doc/BRIEF.md
# Reversible Lifting Rotator

The block rotates a pair of signed integers through a fixed angle using three shear (lifting) steps in sequence. The first step adds a scaled copy of the second value to the first. The second step subtracts a scaled copy of that new first value from the second. The third step again adds a scaled copy of the updated second value to the first. Each scaling is a multiply by a signed Q1.14 constant, followed by an arithmetic right shift of 14 bits, which is a floor. Two constants are set as parameters: the half-angle tangent and the sine. The half-angle tangent is used by both outer steps.

A mode input selects forward or inverse operation for each sample. Inverse mode runs the three steps in reverse order with the signs flipped. Because both directions round the same way, a forward result fed back in inverse mode returns the original integers exactly. A chain of such rotators can therefore build integer-to-integer transforms that reconstruct perfectly.

The block has one register stage per lifting step. A sample is accepted every cycle, and the mode bit travels down the pipeline with its own data. The working values carry one extra bit of headroom. The outputs are truncated back to the input width.

Top module: `lift_rotator`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and both output words are 0. A reset asserted mid-stream discards every sample in flight.
- R2: A sample accepted with `in_valid`=1 at a clock edge appears with `out_valid`=1 exactly 3 rising edges later. The block accepts one sample per cycle, and every accepted sample produces exactly one output.
- R3: With `in_inv`=0 (forward), the output follows t = a + fl(b·T), y = b − fl(t·S), x = t + fl(y·T). Here fl(v·c) is floor(v·c / 2^14), T is the signed Q1.14 half-angle tangent, and S is the signed Q1.14 sine.
- R4: With `in_inv`=1 (inverse), the output follows t = a − fl(b·T), y = b + fl(t·S), x = t − fl(y·T), with the same fl, T and S as in R3.
- R5: If both inputs have magnitude at most 2^(W−2)−8, a forward output fed back with `in_inv`=1 returns the original pair bit-exactly.
- R6: Each sample is processed in its own mode, even when forward and inverse samples alternate on consecutive cycles.
- R7: While `out_valid` is 0, `out_x` and `out_y` hold their last values. Input words presented with `in_valid`=0 have no effect.
- R8: Every scaled product rounds toward negative infinity. For example, a forward pass on (0, −1) gives (−1, 0), and a pass on (0, 0) gives (0, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_inv | input | 1 | 0 forward rotation, 1 inverse rotation |
| in_x | input | W | First input value, signed |
| in_y | input | W | Second input value, signed |
| out_valid | output | 1 | Output sample present |
| out_x | output | W | First result value, signed |
| out_y | output | W | Second result value, signed |

## Verification
Every result is due on the third rising edge after its sample was driven. The bench drives on falling edges and counts rising edges. For each sample it queues the expected pair together with the edge count at which the sample was issued. The monitor samples outputs on falling edges only. Each time `out_valid` is high, it pops the oldest entry and checks both the pair and that exactly three edges have elapsed. This holds whether the stream is back-to-back, has gaps, or mixes modes.

// File: rtl/lift_rotator.sv
module lift_rotator #(
  parameter int W = 16,
  parameter int CW = 16,
  parameter int FRAC = 14,
  parameter logic signed [CW-1:0] TAN_HALF = 16'sd5324,
  parameter logic signed [CW-1:0] SIN_TH = 16'sd9630
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_inv,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  output logic                out_valid,
  output logic signed [W-1:0] out_x,
  output logic signed [W-1:0] out_y
);
  localparam int IW = W + 1;
  localparam int PW = IW + CW;

  function automatic logic signed [IW-1:0] shear(input logic signed [IW-1:0] v,
                                                 input logic signed [CW-1:0] c);
    logic signed [PW-1:0] p;
    p = PW'(v) * PW'(c);
    return IW'(p >>> FRAC);
  endfunction

  logic                 v1, v2, m1, m2, m3;
  logic signed [IW-1:0] x1, y1, x2, y2;
  logic signed [W-1:0]  x3, y3;
  logic signed [IW-1:0] x0, y0;

  assign x0 = IW'(in_x);
  assign y0 = IW'(in_y);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; out_valid <= 1'b0;
      m1 <= 1'b0; m2 <= 1'b0; m3 <= 1'b0;
      x1 <= '0; y1 <= '0; x2 <= '0; y2 <= '0; x3 <= '0; y3 <= '0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
      if (in_valid) begin
        m1 <= in_inv;
        x1 <= in_inv ? x0 - shear(y0, TAN_HALF) : x0 + shear(y0, TAN_HALF);
        y1 <= y0;
      end
      if (v1) begin
        m2 <= m1;
        x2 <= x1;
        y2 <= m1 ? y1 + shear(x1, SIN_TH) : y1 - shear(x1, SIN_TH);
      end
      if (v2) begin
        m3 <= m2;
        x3 <= W'(m2 ? x2 - shear(y2, TAN_HALF) : x2 + shear(y2, TAN_HALF));
        y3 <= W'(y2);
      end
    end
  end

  assign out_x = x3;
  assign out_y = y3;
endmodule

// File: rtl/lift_rotator_chk.sv
module lift_rotator_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_inv,
  input logic         out_valid,
  input logic [W-1:0] out_x,
  input logic [W-1:0] out_y,
  input logic         out_inv
);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    warm == 2'd0 |-> (!out_valid && out_x == '0 && out_y == '0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm == 2'd3 |-> out_valid == $past(in_valid, 3));

  assert_mode_travel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && out_valid) |-> out_inv == $past(in_inv, 3));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_x) && $stable(out_y)));
endmodule

bind lift_rotator lift_rotator_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inv(in_inv),
  .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_inv(m3)
);

// File: tb/sim_lift_rotator.sv
module sim_lift_rotator;
  localparam int W = 16;
  localparam logic signed [15:0] TH = 16'sd5324;
  localparam logic signed [15:0] SN = 16'sd9630;
  localparam int LIM = (1 << (W - 2)) - 8;

  typedef struct packed {
    logic inv;
    logic signed [15:0] a, b, ea, eb;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{1'b0, 16'sd0,     16'sd0,    16'sd0,    16'sd0},    // R8 zero
    '{1'b0, 16'sd0,    -16'sd1,   -16'sd1,    16'sd0},    // R8 floor
    '{1'b0, 16'sd1000,  16'sd0,    16'sd809, -16'sd587},  // R3
    '{1'b1, 16'sd809,  -16'sd587,  16'sd1000, 16'sd0},    // R4
    '{1'b0, 16'sd0,     16'sd1000, 16'sd587,  16'sd810},  // R3
    '{1'b1, 16'sd587,   16'sd810,  16'sd0,    16'sd1000}, // R4
    '{1'b0, -16'sd1000, 16'sd0,   -16'sd809,  16'sd588}   // R3
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_inv = 1'b0;
  logic signed [W-1:0] in_x = '0, in_y = '0;
  logic out_valid;
  logic signed [W-1:0] out_x, out_y;

  int checks = 0, fails = 0;
  longint cyc = 0;
  bit capture = 0;
  longint qx[$], qy[$], qt[$];
  string qr[$];
  longint cx[$], cy[$], ox[$], oy[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  lift_rotator #(.W(W), .TAN_HALF(TH), .SIN_TH(SN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inv(in_inv),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_x(out_x), .out_y(out_y));

  function automatic longint fl(longint v, longint c);
    return (v * c) >>> 14;
  endfunction

  task automatic model(input bit inv, input longint a, input longint b,
                       output longint ra, output longint rb);
    longint t;
    if (!inv) begin
      t = a + fl(b, TH); rb = b - fl(t, SN); ra = t + fl(rb, TH);
    end else begin
      t = a - fl(b, TH); rb = b + fl(t, SN); ra = t - fl(rb, TH);
    end
  endtask

  task automatic check(bit ok, string r, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic issue(bit inv, longint a, longint b, longint ea, longint eb, string r);
    in_valid = 1'b1; in_inv = inv; in_x = W'(a); in_y = W'(b);
    qx.push_back(ea); qy.push_back(eb); qt.push_back(cyc); qr.push_back(r);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (qx.size() == 0) begin
        check(0, "R2 unexpected output", 1, 0);
      end else begin
        longint ex, ey, et;
        string r;
        ex = qx.pop_front(); ey = qy.pop_front(); et = qt.pop_front(); r = qr.pop_front();
        check(longint'(out_x) == ex, {r, " x"}, longint'(out_x), ex);
        check(longint'(out_y) == ey, {r, " y"}, longint'(out_y), ey);
        check(cyc - et == 3, "R2 latency", cyc - et, 3);
        if (capture) begin cx.push_back(longint'(out_x)); cy.push_back(longint'(out_y)); end
      end
    end
  end

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    longint ra, rb, a, b, hx, hy;
    bit inv;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_x == '0 && out_y == '0, "R1 in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_x == '0 && out_y == '0, "R1 after release", out_valid, 0);

    for (int i = 0; i < 7; i++)
      issue(VT[i].inv, VT[i].a, VT[i].b, VT[i].ea, VT[i].eb, VT[i].inv ? "R4 table" : "R3/R8 table");
    idle(6);
    check(qx.size() == 0, "R2 drained", qx.size(), 0);

    hx = out_x; hy = out_y;
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b0; in_inv = i[0]; in_x = W'($urandom); in_y = W'($urandom);
      @(negedge clk);
      check(out_valid == 1'b0, "R7 no valid", out_valid, 0);
      check(longint'(out_x) == hx && longint'(out_y) == hy, "R7 hold", longint'(out_x), hx);
    end

    capture = 1;
    for (int i = 0; i < 200; i++) begin
      a = longint'($urandom_range(2 * LIM, 0)) - LIM;
      b = longint'($urandom_range(2 * LIM, 0)) - LIM;
      ox.push_back(a); oy.push_back(b);
      model(0, a, b, ra, rb);
      issue(0, a, b, ra, rb, "R3 random");
      if ($urandom_range(3, 0) == 0) idle(1);
    end
    idle(6);
    capture = 0;
    check(cx.size() == 200, "R2 count", cx.size(), 200);

    while (cx.size() > 0) begin
      issue(1, cx.pop_front(), cy.pop_front(), ox.pop_front(), oy.pop_front(), "R5 round trip");
    end
    idle(6);

    for (int i = 0; i < 200; i++) begin
      inv = i[0] ^ ($urandom_range(3, 0) == 0);
      a = longint'($urandom_range(2 * LIM, 0)) - LIM;
      b = longint'($urandom_range(2 * LIM, 0)) - LIM;
      model(inv, a, b, ra, rb);
      issue(inv, a, b, ra, rb, inv ? "R6 mixed inverse" : "R6 mixed forward");
    end
    idle(6);
    check(qx.size() == 0, "R2 drained mixed", qx.size(), 0);

    issue(0, 1000, 0, 809, -587, "R1 flush");
    issue(1, 809, -587, 1000, 0, "R1 flush");
    in_valid = 1'b0;
    rst_n = 1'b0;
    qx.delete(); qy.delete(); qt.delete(); qr.delete();
    #1;
    check(out_valid == 1'b0 && out_x == '0 && out_y == '0, "R1 mid-stream reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(5);
    check(out_valid == 1'b0, "R1 flushed", out_valid, 0);

    summary();
  end
endmodule